// File: doc/BRIEF.md
# Multi-Lane Serial Byte Receiver

This block rebuilds bytes from a serial flash-style link that moves one, two or four bits per clock edge. It watches the serial clock, the active-low chip select and four data lines. It brings all of them into the system clock domain and finds the sampling edges of the serial clock. It shifts in the bits of each sampling edge and emits each finished byte with a one-cycle strobe.

The clock polarity and phase inputs select which serial clock edge samples data. A lane-count input selects standard, dual or quad transfer. A direction input selects, in single-lane transfers, whether host-driven or device-driven data is captured. The lane count and direction are held steady for each chip-select window.

When chip select rises part-way through a byte, the block drops the partial bits and gives a one-cycle pulse to report the short byte. When a sampling edge arrives with a lane count it cannot use, the block latches an error and stops emitting bytes until reset.

Top module: `sio_byte_rx`

## Requirements
- R1: After synchronous reset, `byte_valid`, `byte_short` and `lane_err` are 0 and `byte_data` is 0x00.
- R2: With `lane_cnt` = 1, each sampling edge takes one bit: from `spi_sio[1]` when `from_device` = 1, and from `spi_sio[0]` when `from_device` = 0. The other line is ignored, and a byte takes 8 sampling edges.
- R3: With `lane_cnt` = 2, each sampling edge takes `spi_sio[1]` as the higher bit and `spi_sio[0]` as the next lower bit. A byte takes 4 sampling edges.
- R4: With `lane_cnt` = 4, each sampling edge takes `spi_sio[3]`, `spi_sio[2]`, `spi_sio[1]` and `spi_sio[0]` as four consecutive bits, highest first. A byte takes 2 sampling edges.
- R5: Bits fill the byte from bit 7 down to bit 0, so the first sampled bit is the MSB. On the edge that completes a byte, `byte_valid` is high for exactly one cycle and `byte_data` holds the byte. `byte_data` keeps that value until the next byte.
- R6: Sampling happens on the rising serial clock edge when {`clk_pol`,`clk_pha`} is 00 or 11. It happens on the falling edge when {`clk_pol`,`clk_pha`} is 01 or 10. The other edge never samples.
- R7: `byte_valid` first reads high after the (SYNC_STAGES+1)-th system clock rising edge that follows the completing serial clock edge, and not earlier.
- R8: Serial clock edges are ignored while `spi_csb` is high. A rising `spi_csb` clears the bit count. If it rises with 1 to 7 bits collected, `byte_short` pulses for one cycle and no `byte_valid` follows for those bits.
- R9: If a sampling edge occurs with `lane_cnt` not equal to 1, 2 or 4, `lane_err` goes to 1 and stays at 1 until reset. While `lane_err` is 1, neither `byte_valid` nor `byte_short` is asserted.
- R10: A `spi_csb` rise on a byte boundary, with no bits pending, gives no `byte_short`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock, asynchronous to `clk` |
| spi_csb | input | 1 | Chip select, active low |
| spi_sio | input | 4 | Serial data lines |
| clk_pol | input | 1 | Serial clock idle level |
| clk_pha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| lane_cnt | input | 3 | Lanes per edge: 1, 2 or 4 |
| from_device | input | 1 | Single-lane source: 1 = device line, 0 = host line |
| byte_data | output | 8 | Last completed byte |
| byte_valid | output | 1 | One-cycle strobe for a new byte |
| byte_short | output | 1 | One-cycle pulse for a byte cut off by chip select |
| lane_err | output | 1 | Sticky illegal lane count flag |

## Verification
Each serial-side change takes SYNC_STAGES register stages to reach the edge detector, plus one output register. So a strobe or pulse is due on the (SYNC_STAGES+1)-th system clock rise after the serial clock or chip-select change. The bench drives all inputs on falling system clock edges and holds every serial clock level for several system clocks. A monitor records every strobe and pulse on falling edges, so none can be missed. One dedicated test counts the edges exactly: the strobe must still be low after SYNC_STAGES rises and high after one more. In the sweep, the bench changes the data lines between the two serial clock edges of each bit, so sampling on the wrong edge produces a wrong byte.

// File: rtl/sio_rx_pkg.sv
package sio_rx_pkg;

    localparam int BYTE_W   = 8;
    localparam int LANE_MAX = 4;
    localparam int CNT_W    = $clog2(BYTE_W) + 1;

    // Bits captured on one sampling edge, right-aligned, and how many of them
    typedef struct packed {
        logic [LANE_MAX-1:0] bits;
        logic [2:0]          width;
    } beat_t;

    function automatic logic lanes_ok(input logic [2:0] n);
        case (n)
            3'd1, 3'd2, 3'd4: return 1'b1;
            default:          return 1'b0;
        endcase
    endfunction

    // Rising edge samples when polarity equals phase
    function automatic logic samples_on_rise(input logic pol, input logic pha);
        return pol == pha;
    endfunction

endpackage

// File: rtl/sio_rx_sync.sv
module sio_rx_sync
    import sio_rx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                spi_sck,
    input  logic                spi_csb,
    input  logic [LANE_MAX-1:0] spi_sio,
    input  logic                clk_pol,
    input  logic                clk_pha,
    output logic                sample_ev,
    output logic                csb_rise,
    output logic [LANE_MAX-1:0] sio_s
);

    logic [STAGES-1:0]   sck_q;
    logic [STAGES-1:0]   csb_q;
    logic [LANE_MAX-1:0] sio_q [STAGES];
    logic                sck_d;
    logic                csb_d;
    logic                sck_now;
    logic                csb_now;
    logic                rise_ev;
    logic                fall_ev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= '0;
            csb_q <= '1;
            for (int i = 0; i < STAGES; i++) sio_q[i] <= '0;
            sck_d <= 1'b0;
            csb_d <= 1'b1;
        end else begin
            for (int i = STAGES - 1; i > 0; i--) begin
                sck_q[i] <= sck_q[i-1];
                csb_q[i] <= csb_q[i-1];
                sio_q[i] <= sio_q[i-1];
            end
            sck_q[0] <= spi_sck;
            csb_q[0] <= spi_csb;
            sio_q[0] <= spi_sio;
            sck_d    <= sck_q[STAGES-1];
            csb_d    <= csb_q[STAGES-1];
        end
    end

    assign sck_now = sck_q[STAGES-1];
    assign csb_now = csb_q[STAGES-1];
    assign sio_s   = sio_q[STAGES-1];
    assign rise_ev = sck_now & ~sck_d;
    assign fall_ev = ~sck_now & sck_d;

    always_comb begin
        sample_ev = samples_on_rise(clk_pol, clk_pha) ? rise_ev : fall_ev;
        sample_ev = sample_ev & ~csb_now;
    end

    assign csb_rise = csb_now & ~csb_d;

endmodule

// File: rtl/sio_rx_lane_sel.sv
module sio_rx_lane_sel
    import sio_rx_pkg::*;
(
    input  logic [LANE_MAX-1:0] sio_s,
    input  logic [2:0]          lane_cnt,
    input  logic                from_device,
    output beat_t               beat
);

    always_comb begin
        beat = '0;
        case (lane_cnt)
            3'd1: begin
                beat.bits  = {3'b000, from_device ? sio_s[1] : sio_s[0]};
                beat.width = 3'd1;
            end
            3'd2: begin
                beat.bits  = {2'b00, sio_s[1], sio_s[0]};
                beat.width = 3'd2;
            end
            3'd4: begin
                beat.bits  = sio_s;
                beat.width = 3'd4;
            end
            default: beat = '0;
        endcase
    end

endmodule

// File: rtl/sio_rx_assemble.sv
module sio_rx_assemble
    import sio_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_ev,
    input  logic              csb_rise,
    input  logic              lanes_good,
    input  beat_t             beat,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_valid,
    output logic              byte_short,
    output logic              lane_err
);

    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] shifted;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  cnt_next;
    logic              full;

    always_comb begin
        case (beat.width)
            3'd1:    shifted = {shreg[BYTE_W-2:0], beat.bits[0]};
            3'd2:    shifted = {shreg[BYTE_W-3:0], beat.bits[1:0]};
            3'd4:    shifted = {shreg[BYTE_W-5:0], beat.bits};
            default: shifted = shreg;
        endcase
        cnt_next = cnt + CNT_W'(beat.width);
        full     = cnt_next >= CNT_W'(BYTE_W);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg      <= '0;
            cnt        <= '0;
            byte_data  <= '0;
            byte_valid <= 1'b0;
            byte_short <= 1'b0;
            lane_err   <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            byte_short <= 1'b0;
            if (csb_rise) begin
                byte_short <= (cnt != '0) && !lane_err;
                cnt        <= '0;
            end else if (sample_ev && !lane_err) begin
                if (!lanes_good) begin
                    lane_err <= 1'b1;
                end else if (full) begin
                    byte_data  <= shifted;
                    byte_valid <= 1'b1;
                    cnt        <= '0;
                end else begin
                    shreg <= shifted;
                    cnt   <= cnt_next;
                end
            end
        end
    end

    // R5: strobe lasts one cycle and follows a sampling edge
    a_r5_single_strobe: assert property (@(posedge clk) disable iff (rst)
        byte_valid |=> !byte_valid);
    a_r5_strobe_from_edge: assert property (@(posedge clk) disable iff (rst)
        byte_valid |-> $past(sample_ev));
    // R5: pending bit count stays below a full byte
    a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt < CNT_W'(BYTE_W));
    // R8: short pulse only after a chip-select rise, never with a strobe
    a_r8_short_from_csb: assert property (@(posedge clk) disable iff (rst)
        byte_short |-> $past(csb_rise));
    a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(byte_short && byte_valid));
    // R9: error is sticky and silences the outputs
    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        lane_err |=> lane_err);
    a_r9_silent: assert property (@(posedge clk) disable iff (rst)
        lane_err |-> !byte_valid && !byte_short);

endmodule

// File: rtl/sio_byte_rx.sv
module sio_byte_rx
    import sio_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       spi_sck,
    input  logic       spi_csb,
    input  logic [3:0] spi_sio,
    input  logic       clk_pol,
    input  logic       clk_pha,
    input  logic [2:0] lane_cnt,
    input  logic       from_device,
    output logic [7:0] byte_data,
    output logic       byte_valid,
    output logic       byte_short,
    output logic       lane_err
);

    logic                sample_ev;
    logic                csb_rise;
    logic [LANE_MAX-1:0] sio_s;
    beat_t               beat;
    logic                lanes_good;

    sio_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .spi_sck   (spi_sck),
        .spi_csb   (spi_csb),
        .spi_sio   (spi_sio),
        .clk_pol   (clk_pol),
        .clk_pha   (clk_pha),
        .sample_ev (sample_ev),
        .csb_rise  (csb_rise),
        .sio_s     (sio_s)
    );

    sio_rx_lane_sel u_sel (
        .sio_s       (sio_s),
        .lane_cnt    (lane_cnt),
        .from_device (from_device),
        .beat        (beat)
    );

    assign lanes_good = lanes_ok(lane_cnt);

    sio_rx_assemble u_asm (
        .clk        (clk),
        .rst        (rst),
        .sample_ev  (sample_ev),
        .csb_rise   (csb_rise),
        .lanes_good (lanes_good),
        .beat       (beat),
        .byte_data  (byte_data),
        .byte_valid (byte_valid),
        .byte_short (byte_short),
        .lane_err   (lane_err)
    );

    // R8: no byte strobe in the cycle a chip-select rise is seen
    a_r8_no_strobe_on_rise: assert property (@(posedge clk) disable iff (rst)
        $past(csb_rise) |-> !byte_valid);

endmodule

// File: tb/tb_sio_byte_rx.sv
`timescale 1ns/1ps
module tb_sio_byte_rx;

    localparam int SYNC = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       spi_sck = 1'b0;
    logic       spi_csb = 1'b1;
    logic [3:0] spi_sio = 4'h0;
    logic       clk_pol = 1'b0;
    logic       clk_pha = 1'b0;
    logic [2:0] lane_cnt = 3'd1;
    logic       from_device = 1'b0;
    logic [7:0] byte_data;
    logic       byte_valid;
    logic       byte_short;
    logic       lane_err;

    int errors = 0;
    int checks = 0;
    int ngot = 0;
    int nshort = 0;
    logic [7:0] got [16];
    bit done = 1'b0;

    sio_byte_rx #(.SYNC_STAGES(SYNC)) dut (
        .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_csb(spi_csb),
        .spi_sio(spi_sio), .clk_pol(clk_pol), .clk_pha(clk_pha),
        .lane_cnt(lane_cnt), .from_device(from_device),
        .byte_data(byte_data), .byte_valid(byte_valid),
        .byte_short(byte_short), .lane_err(lane_err)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        if (!rst) begin
            if (byte_valid) begin
                if (ngot < 16) got[ngot] = byte_data;
                ngot++;
            end
            if (byte_short) nshort++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [3:0] lane_pat(input logic [2:0] ln, input logic dev, input logic [3:0] g);
        case (ln)
            3'd1:    return dev ? {2'b00, g[0], ~g[0]} : {2'b00, ~g[0], g[0]};
            3'd2:    return {2'b00, g[1:0]};
            default: return g;
        endcase
    endfunction

    function automatic logic [3:0] group_of(input logic [7:0] b, input int w, input int g);
        logic [7:0] sh;
        sh = b << (w * g);
        case (w)
            1:       return {3'b000, sh[7]};
            2:       return {2'b00, sh[7:6]};
            default: return sh[7:4];
        endcase
    endfunction

    // One serial clock period; data lines hold garbage around the non-sampling edge
    task automatic put_group(input logic [3:0] g);
        logic [3:0] good;
        logic [3:0] bad;
        good = lane_pat(lane_cnt, from_device, g);
        bad  = lane_pat(lane_cnt, from_device, ~g);
        if (!clk_pha) begin
            spi_sio = good;  wait_clk(4);
            spi_sck = ~clk_pol; wait_clk(4);
            spi_sio = bad;   wait_clk(2);
            spi_sck = clk_pol; wait_clk(4);
        end else begin
            spi_sio = bad;   wait_clk(4);
            spi_sck = ~clk_pol; wait_clk(2);
            spi_sio = good;  wait_clk(4);
            spi_sck = clk_pol; wait_clk(4);
        end
    endtask

    task automatic put_byte(input logic [7:0] b);
        int w;
        w = int'(lane_cnt);
        for (int g = 0; g < 8 / w; g++) put_group(group_of(b, w, g));
    endtask

    task automatic open_cs();
        spi_sck = clk_pol; wait_clk(4);
        spi_csb = 1'b0;    wait_clk(4);
    endtask

    task automatic close_cs();
        wait_clk(4);
        spi_csb = 1'b1; wait_clk(8);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        wait_clk(3);
        rst = 1'b0;
        wait_clk(2);
        ngot = 0; nshort = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] b0;
        logic [7:0] b1;
        int s0;
        string tag;
        wait_clk(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 valid", 32'(byte_valid), 0);
        check("R1 short", 32'(byte_short), 0);
        check("R1 err", 32'(lane_err), 0);
        check("R1 data", 32'(byte_data), 0);

        // Sweep: four clock modes, three lane counts, both directions (R2 R3 R4 R5 R6 R10)
        for (int m = 0; m < 4; m++) begin
            for (int li = 0; li < 3; li++) begin
                for (int d = 0; d < 2; d++) begin
                    clk_pol = m[1]; clk_pha = m[0];
                    lane_cnt = 3'(1 << li); from_device = d[0];
                    b0 = 8'(8'hA5 + 37 * (m * 6 + li * 2 + d));
                    b1 = {b0[3:0], ~b0[7:4]} ^ 8'h3C;
                    tag = (li == 0) ? "R2 R6" : (li == 1) ? "R3 R6" : "R4 R6";
                    ngot = 0; s0 = nshort;
                    open_cs();
                    put_byte(b0);
                    put_byte(b1);
                    close_cs();
                    check({tag, " R5 count"}, 32'(ngot), 2);
                    check({tag, " R5 byte0"}, 32'(got[0]), 32'(b0));
                    check({tag, " R5 byte1"}, 32'(got[1]), 32'(b1));
                    check("R10 no short", 32'(nshort - s0), 0);
                end
            end
        end

        // R7 exact strobe timing, mode 0, single lane host
        clk_pol = 1'b0; clk_pha = 1'b0; lane_cnt = 3'd1; from_device = 1'b0;
        ngot = 0;
        open_cs();
        b0 = 8'h6B;
        for (int g = 0; g < 7; g++) put_group(group_of(b0, 1, g));
        spi_sio = lane_pat(3'd1, 1'b0, group_of(b0, 1, 7));
        wait_clk(4);
        spi_sck = 1'b1;
        repeat (SYNC) @(posedge clk);
        @(negedge clk);
        check("R7 not early", 32'(byte_valid), 0);
        @(posedge clk);
        @(negedge clk);
        check("R7 on time", 32'(byte_valid), 1);
        check("R7 data", 32'(byte_data), 32'(b0));
        wait_clk(4);
        spi_sck = 1'b0; wait_clk(4);
        close_cs();
        check("R7 one byte", 32'(ngot), 1);

        // R8 short byte in single-lane mode, then counter restarts cleanly
        ngot = 0; s0 = nshort;
        open_cs();
        for (int g = 0; g < 3; g++) put_group(4'h1);
        close_cs();
        check("R8 short pulse", 32'(nshort - s0), 1);
        check("R8 no byte", 32'(ngot), 0);
        open_cs(); put_byte(8'hC3); close_cs();
        check("R8 restart count", 32'(ngot), 1);
        check("R8 restart data", 32'(got[0]), 32'hC3);

        // R8 short in quad mode after one edge
        lane_cnt = 3'd4; ngot = 0; s0 = nshort;
        open_cs(); put_group(4'h9); close_cs();
        check("R8 quad short", 32'(nshort - s0), 1);
        check("R8 quad no byte", 32'(ngot), 0);

        // R8 edges with chip select high are ignored
        lane_cnt = 3'd1; ngot = 0; s0 = nshort;
        spi_csb = 1'b1;
        for (int g = 0; g < 5; g++) put_group(4'h1);
        check("R8 ignored no byte", 32'(ngot), 0);
        open_cs(); put_byte(8'h2D); close_cs();
        check("R8 ignored clean byte", 32'(got[0]), 32'h2D);
        check("R8 ignored no short", 32'(nshort - s0), 0);

        // R9 illegal lane count 3
        ngot = 0; s0 = nshort;
        lane_cnt = 3'd3;
        open_cs(); put_group(4'h5);
        check("R9 err set", 32'(lane_err), 1);
        lane_cnt = 3'd1;
        put_byte(8'h81); put_byte(8'h42);
        close_cs();
        open_cs(); put_byte(8'h99); close_cs();
        check("R9 no bytes", 32'(ngot), 0);
        check("R9 no short", 32'(nshort - s0), 0);
        check("R9 sticky", 32'(lane_err), 1);

        // R9 cleared by reset, R1 again, then lane count 0 also illegal
        do_reset();
        check("R9 cleared", 32'(lane_err), 0);
        open_cs(); put_byte(8'h5E); close_cs();
        check("R9 after reset", 32'(got[0]), 32'h5E);
        lane_cnt = 3'd0; ngot = 0;
        open_cs(); put_group(4'h3); put_group(4'h3); close_cs();
        check("R9 zero lanes err", 32'(lane_err), 1);
        check("R9 zero lanes no byte", 32'(ngot), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule